// File: doc/BRIEF.md
# DRAM Mode Register File

This block is the device-side model of the four programmable mode registers of a DDR3-style memory. A mode-register-set strobe carries a two-bit bank select, which picks one of the four registers, and a 16-bit address payload, which replaces that register's whole content. The block holds the registers and presents decoded controls taken from register 1. These controls are output enable, termination-strobe enable against data-mask enable, write leveling, the additive-latency selector and the drive-strength selector. A read port returns any register for observation.

The block also tracks the delay-locked loop. A four-state machine follows the register-1 enable bit, the self-clearing reset request in register 0 bit 8, and the self-refresh entry and exit pulses. The states are:

- `DLL_OFF`: not running. After a reset the machine starts here.
- `DLL_LOCK`: reset in progress. It lasts `LOCK_CYC` cycles.
- `DLL_RUN`: locked and usable.
- `DLL_SR`: parked while in self refresh.

The transitions are:

- OFF→LOCK: a reset request arrives while the enable bit is 0.
- LOCK→RUN: the lock count has expired.
- LOCK→OFF and RUN→OFF: the enable bit reads 1.
- LOCK→SR and RUN→SR: self-refresh entry.
- RUN→LOCK: a new reset request.
- SR→LOCK: self-refresh exit.

Self refresh has no effect in OFF, so a DLL that was off before self refresh stays off afterwards.

Top module: `dram_mode_regs`

## Requirements
- R1: A write strobe with `mrs_bank` = b stores `mrs_addr` into register b (0..3), and `rd_data` returns register `rd_bank` combinationally.
- R2: Each write replaces every bit of the selected register. All other registers keep their values until they are rewritten or `rst_n` goes low.
- R3: Bit 8 of register 0 reads 1 in the cycle after a write that sets it, and reads 0 from the next clock edge on. The other bits of register 0 are kept.
- R4: The DLL reports `dll_on` only after a reset request made while register 1 bit 0 is 0. Reporting starts `LOCK_CYC`+1 edges after the write and `dll_locking` is high in between. Writing register 1 bit 0 = 1 drops `dll_on` one edge after the write.
- R5: Self-refresh entry while running drops `dll_on` at that edge. Self-refresh exit enters locking, and `dll_on` returns `LOCK_CYC` edges later.
- R6: A DLL that is off stays off through self-refresh entry and exit. While register 1 bit 0 is 1 it also ignores reset requests.
- R7: `out_en` is the inverse of register 1 bit 12. A 1 in that bit disables the outputs.
- R8: `tdqs_en` equals register 1 bit 11 and `dm_en` is its inverse.
- R9: `wlvl_en` equals register 1 bit 7, `al_sel` equals register 1 bits [4:3], and `drv_sel` equals {bit 5, bit 1}.
- R10: Some register-1 writes are rejected. These are writes with any of bits 8, 10, 13, 14 or 15 set, and writes with bits [4:3] = 11. A rejected write leaves register 1 unchanged and raises `mrs_err` for exactly one cycle. Any write that is not to register 1 leaves `mrs_err` low.
- R11: While and after `rst_n` is low, all registers read 0, `dll_on` and `dll_locking` are 0, and `mrs_err` is 0.
- R12: A pending reset request and a self-refresh entry can arrive in the same cycle while the DLL is running. In that case self refresh wins: the DLL parks off, the request is dropped with bit 8 cleared, and exit then relocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mrs_valid | input | 1 | Mode-register-set strobe |
| mrs_bank | input | 2 | Register select |
| mrs_addr | input | 16 | Register payload |
| sr_enter | input | 1 | Self-refresh entry pulse |
| sr_exit | input | 1 | Self-refresh exit pulse |
| rd_bank | input | 2 | Read select |
| rd_data | output | 16 | Selected register content |
| out_en | output | 1 | Data and strobe outputs enabled |
| tdqs_en | output | 1 | Termination strobe active |
| dm_en | output | 1 | Data mask active |
| wlvl_en | output | 1 | Write leveling enabled |
| al_sel | output | 2 | Additive latency code (0: none, 1: CL-1, 2: CL-2) |
| drv_sel | output | 2 | Drive strength code |
| dll_on | output | 1 | DLL locked and running |
| dll_locking | output | 1 | DLL reset in progress |
| mrs_err | output | 1 | One-cycle pulse on a rejected write |

## Verification
A pending DLL reset request and a self-refresh entry can land in the same cycle. The bench provokes this by writing register 0 bit 8 while the DLL runs, then asserting `sr_enter` in the very next cycle, so both reach the machine at one edge. The bench judges the result by checking three things:

- `dll_on` and `dll_locking` are both low after that edge.
- Register 0 bit 8 has cleared.
- The later self-refresh exit relocks in exactly `LOCK_CYC` edges.

Register 1 is also swept over all 2048 combinations of its defined bits, with decoded outputs and rejections computed arithmetically.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    localparam int MR_W   = 16;
    localparam int NUM_MR = 4;
    localparam int SEL_W  = $clog2(NUM_MR);

    // bit positions the decoders depend on
    localparam int B_DLL_DIS  = 0;
    localparam int B_DRV_LO   = 1;
    localparam int B_AL_LO    = 3;
    localparam int B_AL_HI    = 4;
    localparam int B_DRV_HI   = 5;
    localparam int B_WLVL     = 7;
    localparam int B_TDQS     = 11;
    localparam int B_QOFF     = 12;
    localparam int B_DLL_RST  = 8;

    localparam logic [MR_W-1:0] MR1_RSVD =
        MR_W'((1 << 8) | (1 << 10) | (1 << 13) | (1 << 14) | (1 << 15));

    typedef enum logic [1:0] {
        DLL_OFF  = 2'd0,
        DLL_LOCK = 2'd1,
        DLL_RUN  = 2'd2,
        DLL_SR   = 2'd3
    } dll_state_t;
endpackage

// File: rtl/dmr_regfile.sv
module dmr_regfile
    import dmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [MR_W-1:0]  wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [MR_W-1:0]  rd_data,
    output logic [MR_W-1:0]  mr0_q,
    output logic [MR_W-1:0]  mr1_q,
    output logic             err_q
);
    logic [MR_W-1:0] regs [NUM_MR];
    logic            mr1_bad;

    assign mr1_bad = (|(wr_data & MR1_RSVD)) || (wr_data[B_AL_HI:B_AL_LO] == 2'b11);

    for (genvar g = 0; g < NUM_MR; g++) begin : g_reg
        logic [MR_W-1:0] q;
        logic            hit;
        if (g == 1) begin : g_checked
            assign hit = wr_en && (wr_sel == SEL_W'(g)) && !mr1_bad;
        end else begin : g_plain
            assign hit = wr_en && (wr_sel == SEL_W'(g));
        end
        if (g == 0) begin : g_selfclr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             q <= '0;
                else if (hit)           q <= wr_data;
                else if (q[B_DLL_RST])  q[B_DLL_RST] <= 1'b0;
            end
        end else begin : g_hold
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= '0;
                else if (hit) q <= wr_data;
            end
        end
        assign regs[g] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= wr_en && (wr_sel == SEL_W'(1)) && mr1_bad;
    end

    assign rd_data = regs[rd_sel];
    assign mr0_q   = regs[0];
    assign mr1_q   = regs[1];

    AST_MR0_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n) (mr0_q[B_DLL_RST] && !(wr_en && wr_sel == '0 && wr_data[B_DLL_RST])) |=> !mr0_q[B_DLL_RST]); // R3
    AST_MR1_REJECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel == SEL_W'(1) && mr1_bad) |=> (mr1_q == $past(mr1_q))); // R10
    AST_ERR_ONLY_MR1: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && wr_sel == SEL_W'(1)) |=> !err_q); // R10
    AST_FULL_REPLACE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel == SEL_W'(2)) |=> (rd_sel != SEL_W'(2) || rd_data == $past(wr_data))); // R2
endmodule

// File: rtl/dmr_dll_fsm.sv
module dmr_dll_fsm
    import dmr_pkg::*;
#(
    parameter int LOCK_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dll_en_cfg,
    input  logic rst_req,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic dll_on,
    output logic dll_locking
);
    localparam int CNT_W = (LOCK_CYC > 2) ? $clog2(LOCK_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYC - 1);

    dll_state_t       state_q, state_n;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DLL_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= (state_q == DLL_LOCK && state_n == DLL_LOCK) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            DLL_OFF: begin
                if (rst_req && dll_en_cfg) state_n = DLL_LOCK;
            end
            DLL_LOCK: begin
                if (sr_enter)               state_n = DLL_SR;
                else if (!dll_en_cfg)       state_n = DLL_OFF;
                else if (cnt_q == CNT_LAST) state_n = DLL_RUN;
            end
            DLL_RUN: begin
                if (sr_enter)         state_n = DLL_SR;
                else if (!dll_en_cfg) state_n = DLL_OFF;
                else if (rst_req)     state_n = DLL_LOCK;
            end
            DLL_SR: begin
                if (sr_exit) state_n = DLL_LOCK;
            end
            default: state_n = DLL_OFF;
        endcase
    end

    always_comb begin
        dll_on      = 1'b0;
        dll_locking = 1'b0;
        unique case (state_q)
            DLL_RUN:  dll_on      = 1'b1;
            DLL_LOCK: dll_locking = 1'b1;
            default: ;
        endcase
    end

    AST_SR_PARKS: assert property (@(posedge clk) disable iff (!rst_n) (state_q == DLL_RUN && sr_enter) |=> (state_q == DLL_SR)); // R5
    AST_SR_STAYS: assert property (@(posedge clk) disable iff (!rst_n) (state_q == DLL_SR && !sr_exit) |=> !dll_on && !dll_locking); // R5
    AST_CFG_DISABLE: assert property (@(posedge clk) disable iff (!rst_n) (state_q == DLL_RUN && !dll_en_cfg && !sr_enter) |=> (state_q == DLL_OFF)); // R4
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state_q == DLL_LOCK && cnt_q != CNT_LAST && dll_en_cfg && !sr_enter) |=> dll_locking); // R4
    AST_OFF_STAYS: assert property (@(posedge clk) disable iff (!rst_n) (state_q == DLL_OFF && !dll_en_cfg) |=> (state_q == DLL_OFF)); // R6
    AST_SR_BEATS_RST: assert property (@(posedge clk) disable iff (!rst_n) (state_q == DLL_RUN && sr_enter && rst_req) |=> !dll_locking); // R12
endmodule

// File: rtl/dram_mode_regs.sv
module dram_mode_regs
    import dmr_pkg::*;
#(
    parameter int LOCK_CYC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mrs_valid,
    input  logic [1:0]  mrs_bank,
    input  logic [15:0] mrs_addr,
    input  logic        sr_enter,
    input  logic        sr_exit,
    input  logic [1:0]  rd_bank,
    output logic [15:0] rd_data,
    output logic        out_en,
    output logic        tdqs_en,
    output logic        dm_en,
    output logic        wlvl_en,
    output logic [1:0]  al_sel,
    output logic [1:0]  drv_sel,
    output logic        dll_on,
    output logic        dll_locking,
    output logic        mrs_err
);
    logic [MR_W-1:0] mr0_q, mr1_q;

    dmr_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mrs_valid),
        .wr_sel  (mrs_bank),
        .wr_data (mrs_addr),
        .rd_sel  (rd_bank),
        .rd_data (rd_data),
        .mr0_q   (mr0_q),
        .mr1_q   (mr1_q),
        .err_q   (mrs_err)
    );

    dmr_dll_fsm #(.LOCK_CYC(LOCK_CYC)) u_dll (
        .clk         (clk),
        .rst_n       (rst_n),
        .dll_en_cfg  (!mr1_q[B_DLL_DIS]),
        .rst_req     (mr0_q[B_DLL_RST]),
        .sr_enter    (sr_enter),
        .sr_exit     (sr_exit),
        .dll_on      (dll_on),
        .dll_locking (dll_locking)
    );

    always_comb begin
        out_en  = !mr1_q[B_QOFF];
        tdqs_en = mr1_q[B_TDQS];
        dm_en   = !mr1_q[B_TDQS];
        wlvl_en = mr1_q[B_WLVL];
        al_sel  = mr1_q[B_AL_HI:B_AL_LO];
        drv_sel = {mr1_q[B_DRV_HI], mr1_q[B_DRV_LO]};
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !dll_on && !mrs_err); // R11
    AST_DLL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(dll_on && dll_locking)); // R4
    AST_AL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) al_sel != 2'b11); // R10
endmodule

// File: tb/dram_mode_regs_tb.sv
`timescale 1ns/1ps
module dram_mode_regs_tb;
    localparam int LOCK_CYC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mrs_valid = 1'b0;
    logic [1:0]  mrs_bank = '0;
    logic [15:0] mrs_addr = '0;
    logic        sr_enter = 1'b0;
    logic        sr_exit = 1'b0;
    logic [1:0]  rd_bank = '0;
    logic [15:0] rd_data;
    logic        out_en, tdqs_en, dm_en, wlvl_en, dll_on, dll_locking, mrs_err;
    logic [1:0]  al_sel, drv_sel;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] exp_mr [4];

    always #10 clk = ~clk;

    dram_mode_regs #(.LOCK_CYC(LOCK_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .mrs_valid(mrs_valid), .mrs_bank(mrs_bank),
        .mrs_addr(mrs_addr), .sr_enter(sr_enter), .sr_exit(sr_exit),
        .rd_bank(rd_bank), .rd_data(rd_data), .out_en(out_en), .tdqs_en(tdqs_en),
        .dm_en(dm_en), .wlvl_en(wlvl_en), .al_sel(al_sel), .drv_sel(drv_sel),
        .dll_on(dll_on), .dll_locking(dll_locking), .mrs_err(mrs_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic mrs(input logic [1:0] b, input logic [15:0] a);
        mrs_valid = 1'b1;
        mrs_bank  = b;
        mrs_addr  = a;
        tick();
        mrs_valid = 1'b0;
    endtask

    task automatic rd(input logic [1:0] b, output logic [15:0] v);
        rd_bank = b;
        #1;
        v = rd_data;
    endtask

    task automatic chk_all(input string tag);
        logic [15:0] v;
        for (int b = 0; b < 4; b++) begin
            rd(2'(b), v);
            chk(tag, v, exp_mr[b]);
        end
    endtask

    task automatic chk_dec(input string tag);
        logic [15:0] m;
        m = exp_mr[1];
        chk({tag, " R7 out_en"}, out_en, !m[12]);
        chk({tag, " R8 tdqs_en"}, tdqs_en, m[11]);
        chk({tag, " R8 dm_en"}, dm_en, !m[11]);
        chk({tag, " R9 wlvl"}, wlvl_en, m[7]);
        chk({tag, " R9 al"}, al_sel, m[4:3]);
        chk({tag, " R9 drv"}, drv_sel, {m[5], m[1]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] v, a;
        int pos [11] = '{0, 1, 2, 3, 4, 5, 6, 7, 9, 11, 12};
        int rsv [5]  = '{8, 10, 13, 14, 15};
        for (int b = 0; b < 4; b++) exp_mr[b] = '0;

        // R11: reset state
        tick(3);
        chk_all("R11 regs zero in reset");
        chk("R11 dll_on", dll_on, 0);
        chk("R11 mrs_err", mrs_err, 0);
        rst_n = 1'b1;
        tick(2);
        chk_all("R11 regs zero after reset");
        chk("R11 dll_locking", dll_locking, 0);

        // R1 / R2: store and hold sweep on banks 0, 2, 3
        for (int k = 0; k < 16; k++) begin
            for (int b = 0; b < 4; b++) begin
                if (b == 1) continue;
                a = 16'(k * 16'h3A5B + b * 16'h1111) & ~16'h0100;
                mrs(2'(b), a);
                exp_mr[b] = a;
                chk("R2 no error on other banks", mrs_err, 0);
                chk_all("R1 R2 readback");
            end
        end

        // R7 R8 R9 R10: sweep every combination of defined register-1 bits
        for (int i = 0; i < 2048; i++) begin
            a = '0;
            for (int p = 0; p < 11; p++) if (i[p]) a[pos[p]] = 1'b1;
            mrs(2'd1, a);
            if (a[4:3] == 2'b11) begin
                chk("R10 reserved AL error", mrs_err, 1);
            end else begin
                exp_mr[1] = a;
                chk("R10 legal write no error", mrs_err, 0);
            end
            rd(2'd1, v);
            chk("R1 MR1 readback", v, exp_mr[1]);
            chk_dec("sweep");
        end

        // R3 and R4: DLL reset request while enabled
        mrs(2'd1, 16'h0000);
        exp_mr[1] = 16'h0000;
        mrs(2'd0, 16'h0120);
        rd(2'd0, v);
        chk("R3 bit8 visible one cycle", v, 16'h0120);
        tick();
        rd(2'd0, v);
        chk("R3 bit8 self cleared", v, 16'h0020);
        chk("R4 locking entered", dll_locking, 1);
        tick(LOCK_CYC - 1);
        chk("R4 not yet on", dll_on, 0);
        chk("R4 still locking", dll_locking, 1);
        tick();
        chk("R4 on after lock", dll_on, 1);

        // R5: self refresh with DLL running
        sr_enter = 1'b1; tick(); sr_enter = 1'b0;
        chk("R5 off in self refresh", dll_on, 0);
        chk("R5 not locking in self refresh", dll_locking, 0);
        tick(5);
        chk("R5 stays off", dll_on, 0);
        sr_exit = 1'b1; tick(); sr_exit = 1'b0;
        chk("R5 relock on exit", dll_locking, 1);
        tick(LOCK_CYC - 1);
        chk("R5 not yet on", dll_on, 0);
        tick();
        chk("R5 on after relock", dll_on, 1);

        // R4: disabling through register 1 bit 0
        mrs(2'd1, 16'h0001);
        exp_mr[1] = 16'h0001;
        chk("R4 on until next edge", dll_on, 1);
        tick();
        chk("R4 off after disable", dll_on, 0);

        // R6: off DLL through self refresh, reset ignored while disabled
        sr_enter = 1'b1; tick(); sr_enter = 1'b0;
        tick(2);
        sr_exit = 1'b1; tick(); sr_exit = 1'b0;
        tick(3);
        chk("R6 off after exit", dll_on, 0);
        chk("R6 no locking after exit", dll_locking, 0);
        mrs(2'd0, 16'h0100);
        tick(2);
        chk("R6 reset ignored while disabled", dll_locking, 0);
        chk("R6 still off", dll_on, 0);
        rd(2'd0, v);
        chk("R3 bit8 cleared when ignored", v, 16'h0000);

        // re-enable
        mrs(2'd1, 16'h0000);
        exp_mr[1] = 16'h0000;
        mrs(2'd0, 16'h0100);
        tick(LOCK_CYC + 1);
        chk("R4 on after re-enable", dll_on, 1);

        // R12: reset request and self-refresh entry in the same cycle
        mrs(2'd0, 16'h0100);
        sr_enter = 1'b1; tick(); sr_enter = 1'b0;
        chk("R12 not locking", dll_locking, 0);
        chk("R12 not on", dll_on, 0);
        rd(2'd0, v);
        chk("R12 request dropped bit8 clear", v, 16'h0000);
        tick(3);
        chk("R12 parked", dll_on | dll_locking, 0);
        sr_exit = 1'b1; tick(); sr_exit = 1'b0;
        chk("R12 relock after exit", dll_locking, 1);
        tick(LOCK_CYC);
        chk("R12 on after relock", dll_on, 1);

        // R10: each reserved bit rejected
        mrs(2'd1, 16'h1882);
        exp_mr[1] = 16'h1882;
        for (int r = 0; r < 5; r++) begin
            a = 16'h0084;
            a[rsv[r]] = 1'b1;
            mrs(2'd1, a);
            chk("R10 reserved bit error", mrs_err, 1);
            rd(2'd1, v);
            chk("R10 reserved bit keeps value", v, exp_mr[1]);
            chk_dec("R10 kept decode");
            tick();
            chk("R10 error one cycle", mrs_err, 0);
        end

        // R2 / R11: reset clears mid-run
        rst_n = 1'b0;
        tick();
        for (int b = 0; b < 4; b++) exp_mr[b] = '0;
        chk_all("R2 R11 cleared by reset");
        chk("R11 dll off after reset", dll_on, 0);
        rst_n = 1'b1;
        tick();
        chk_dec("R11 decode after reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule